// File: doc/BRIEF.md
# DMA Minor Loop Transfer Sequencer

This block carries out the inner loop of one DMA channel. A single start pulse delivers a complete descriptor: source and destination addresses, signed per-access address steps, source and destination access widths, and a byte count. The block then runs that descriptor as a series of bus reads and writes over a simple request/acknowledge bus that allows one request at a time.

The width of one transfer unit is the wider of the two access sizes. Within each unit the block reads the whole unit from the source and then writes it to the destination. A narrow side takes several accesses per unit. Narrow reads are gathered into a holding word, and a wide read is split into narrow writes. When both sides have the same width, the block alternates one read with one write. When the byte count has been moved, a done pulse reports the final source and destination addresses, so the caller can write them back into its descriptor store.

Top module: `dma_minor_seq`

## Requirements
- R1: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes; code 3 is illegal. The unit width is the larger of the source and destination widths. A run makes exactly byte_count/source_width reads and byte_count/destination_width writes.
- R2: With equal widths, the bus sequence strictly alternates one read and one write, starting with a read.
- R3: With unequal widths, each unit is unit/source_width reads followed by unit/destination_width writes. For example, a 2-byte source with a 4-byte destination gives two 2-byte reads, then one 4-byte write.
- R4: Data is right-justified on bus_rdata and bus_wdata, and unused upper bytes are written as zero. Reads pack little-endian: the k-th read of a unit fills bytes k*source_width upward. The j-th write of a unit carries bytes j*destination_width upward. The destination therefore receives the source byte stream in order.
- R5: The first read uses the start source address, and each accepted read advances the source address by the signed source step. Writes and the destination address behave the same way with the destination step. Addresses wrap modulo 2^AW.
- R6: done is high for exactly one cycle: the cycle after the clock edge that accepts the last write. The final addresses (start address plus access count times step) are valid on the final-address outputs from then until the next accepted start.
- R7: A start is rejected in three cases: a byte count of zero, a byte count that is not a multiple of the unit width, or a size code of 3. A rejected start raises cfg_err for one cycle, in the cycle after start. It makes no bus request and gives no done.
- R8: An access completes at a clock edge where bus_req and bus_ack are both high. Until then, bus_addr, bus_we, bus_size and bus_wdata hold steady.
- R9: A start that arrives while busy is high has no effect on the running transfer.
- R10: After reset, bus_req, busy, done and cfg_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the cfg_* values |
| cfg_src_addr | input | AW | Initial source address |
| cfg_dst_addr | input | AW | Initial destination address |
| cfg_src_step | input | OW | Signed source step per read |
| cfg_dst_step | input | OW | Signed destination step per write |
| cfg_src_size | input | 2 | Source width code |
| cfg_dst_size | input | 2 | Destination width code |
| cfg_nbytes | input | NBW | Bytes to move |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | One-cycle rejected-start pulse |
| final_src_addr | output | AW | Source address after the run |
| final_dst_addr | output | AW | Destination address after the run |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Access width code |
| bus_wdata | output | 32 | Write data, right-justified |
| bus_ack | input | 1 | Access accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The hardest situation to reach is a write whose byte lanes come from different reads while the memory stalls at random points inside the gather or split phase. Only that combination shows both a misplaced lane and a request that changes before it is accepted. The bench reaches it by sweeping every pair of widths against forward, backward and zero steps. A bus model inserts a pseudo-random wait of zero to two cycles before each acknowledge. A zero destination step overwrites one location repeatedly, so only a correctly ordered write sequence leaves the expected final byte.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int LANE_IDX = $clog2(LANES);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_state_e;

  localparam logic [1:0] SZ_ILLEGAL = 2'd3;
endpackage

// File: rtl/dma_seq_addr.sv
module dma_seq_addr #(
  parameter int AW = 16,
  parameter int OW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [AW-1:0]        init,
  input  logic signed [OW-1:0] step_in,
  input  logic                 adv,
  output logic [AW-1:0]        addr
);
  logic [AW-1:0]        addr_q, addr_d;
  logic signed [OW-1:0] step_q, step_d;
  logic signed [AW-1:0] step_ext;

  assign step_ext = AW'(step_q);

  always_comb begin
    addr_d = addr_q;
    step_d = step_q;
    if (load) begin
      addr_d = init;
      step_d = step_in;
    end else if (adv) begin
      addr_d = addr_q + step_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      step_q <= '0;
    end else if (load || adv) begin
      addr_q <= addr_d;
      step_q <= step_d;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_seq_pack.sv
module dma_seq_pack
  import dma_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_lane,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_lane,
  input  logic [1:0]        rd_size,
  output logic [DATA_W-1:0] rd_data
);
  logic [7:0] hold_q [LANES];
  logic [7:0] hold_d [LANES];
  logic [3:0] wr_nb, rd_nb;

  assign wr_nb = 4'd1 << wr_size;
  assign rd_nb = 4'd1 << rd_size;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [2:0] rel;
    logic [2:0] src;
    logic       hit;
    assign rel = 3'(b) - {1'b0, wr_lane};
    assign hit = wr_en && (3'(b) >= {1'b0, wr_lane}) && ({1'b0, rel} < wr_nb);
    assign src = 3'(b) + {1'b0, rd_lane};

    always_comb begin
      hold_d[b] = hold_q[b];
      if (hit) hold_d[b] = wr_data[rel[1:0]*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[b] <= '0;
      else if (hit) hold_q[b] <= hold_d[b];
    end

    always_comb begin
      rd_data[b*8 +: 8] = 8'h00;
      if ((4'(b) < rd_nb) && (src < 3'(LANES))) rd_data[b*8 +: 8] = hold_q[src[1:0]];
    end
  end

  // R4: a gathered access must fit inside the holding word
  p_lane_fit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({2'b00, wr_lane} + wr_nb) <= 4'(LANES));
endmodule

// File: rtl/dma_minor_seq.sv
module dma_minor_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 16,
  parameter int OW  = 16,
  parameter int NBW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     cfg_src_addr,
  input  logic [AW-1:0]     cfg_dst_addr,
  input  logic [OW-1:0]     cfg_src_step,
  input  logic [OW-1:0]     cfg_dst_step,
  input  logic [1:0]        cfg_src_size,
  input  logic [1:0]        cfg_dst_size,
  input  logic [NBW-1:0]    cfg_nbytes,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic [AW-1:0]     final_src_addr,
  output logic [AW-1:0]     final_dst_addr,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  seq_state_e     st_q, st_d;
  logic [1:0]     rcnt_q, rcnt_d, wcnt_q, wcnt_d;
  logic [1:0]     ssz_q, ssz_d, dsz_q, dsz_d;
  logic [NBW-1:0] rem_q, rem_d;
  logic           done_q, done_d, err_q, err_d;

  logic [1:0]     in_unit, u_q, rd_last, wr_last;
  logic [NBW-1:0] in_mask, unit_bytes;
  logic           in_bad, load, rd_hs, wr_hs;
  logic           last_rd, last_wr, last_unit;
  logic [AW-1:0]  src_addr, dst_addr;

  // start-time checks on the incoming descriptor
  assign in_unit = (cfg_src_size < cfg_dst_size) ? cfg_dst_size : cfg_src_size;
  assign in_mask = (NBW'(1) << in_unit) - NBW'(1);
  assign in_bad  = (cfg_src_size == SZ_ILLEGAL) || (cfg_dst_size == SZ_ILLEGAL) ||
                   (cfg_nbytes == '0) || ((cfg_nbytes & in_mask) != '0);
  assign load    = (st_q == ST_IDLE) && start && !in_bad;

  // per-unit access counts of the running descriptor
  assign u_q        = (ssz_q < dsz_q) ? dsz_q : ssz_q;
  assign rd_last    = 2'((3'd1 << (u_q - ssz_q)) - 3'd1);
  assign wr_last    = 2'((3'd1 << (u_q - dsz_q)) - 3'd1);
  assign unit_bytes = NBW'(1) << u_q;
  assign rd_hs      = (st_q == ST_RD) && bus_ack;
  assign wr_hs      = (st_q == ST_WR) && bus_ack;
  assign last_rd    = (rcnt_q == rd_last);
  assign last_wr    = (wcnt_q == wr_last);
  assign last_unit  = (rem_q == unit_bytes);

  always_comb begin
    st_d   = st_q;
    rcnt_d = rcnt_q;
    wcnt_d = wcnt_q;
    rem_d  = rem_q;
    ssz_d  = ssz_q;
    dsz_d  = dsz_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        if (in_bad) begin
          err_d = 1'b1;
        end else begin
          st_d   = ST_RD;
          rcnt_d = '0;
          wcnt_d = '0;
          rem_d  = cfg_nbytes;
          ssz_d  = cfg_src_size;
          dsz_d  = cfg_dst_size;
        end
      end
      ST_RD: if (bus_ack) begin
        if (last_rd) begin
          rcnt_d = '0;
          st_d   = ST_WR;
        end else begin
          rcnt_d = rcnt_q + 2'd1;
        end
      end
      ST_WR: if (bus_ack) begin
        if (last_wr) begin
          wcnt_d = '0;
          if (last_unit) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
          end else begin
            rem_d = rem_q - unit_bytes;
            st_d  = ST_RD;
          end
        end else begin
          wcnt_d = wcnt_q + 2'd1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rcnt_q <= '0;
      wcnt_q <= '0;
      rem_q  <= '0;
      ssz_q  <= '0;
      dsz_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (load || rd_hs) rcnt_q <= rcnt_d;
      if (load || wr_hs) begin
        wcnt_q <= wcnt_d;
        rem_q  <= rem_d;
      end
      if (load) begin
        ssz_q <= ssz_d;
        dsz_q <= dsz_d;
      end
    end
  end

  dma_seq_addr #(.AW(AW), .OW(OW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load), .init(cfg_src_addr),
    .step_in(cfg_src_step), .adv(rd_hs), .addr(src_addr)
  );

  dma_seq_addr #(.AW(AW), .OW(OW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load), .init(cfg_dst_addr),
    .step_in(cfg_dst_step), .adv(wr_hs), .addr(dst_addr)
  );

  dma_seq_pack u_pack (
    .clk(clk), .rst_n(rst_n), .wr_en(rd_hs),
    .wr_lane(2'(rcnt_q << ssz_q)), .wr_size(ssz_q), .wr_data(bus_rdata),
    .rd_lane(2'(wcnt_q << dsz_q)), .rd_size(dsz_q), .rd_data(bus_wdata)
  );

  assign busy           = (st_q != ST_IDLE);
  assign bus_req        = busy;
  assign bus_we         = (st_q == ST_WR);
  assign bus_addr       = bus_we ? dst_addr : src_addr;
  assign bus_size       = bus_we ? dsz_q : ssz_q;
  assign done           = done_q;
  assign cfg_err        = err_q;
  assign final_src_addr = src_addr;
  assign final_dst_addr = dst_addr;

  // R8: an unaccepted request keeps its attributes
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) &&
                            $stable(bus_size) && $stable(bus_wdata));
  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: completion follows an accepted write
  p_done_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_we && bus_ack));
  // R7: a rejected start leaves the bus idle
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !bus_req && !done);
endmodule

// File: tb/tb_dma_minor_seq.sv
`timescale 1ns/1ps
module tb_dma_minor_seq;
  localparam int AW = 16, OW = 16, NBW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [OW-1:0] cfg_src_step = '0, cfg_dst_step = '0;
  logic [1:0] cfg_src_size = '0, cfg_dst_size = '0;
  logic [NBW-1:0] cfg_nbytes = '0;
  logic busy, done, cfg_err, bus_req, bus_we;
  logic [AW-1:0] final_src_addr, final_dst_addr, bus_addr;
  logic [1:0] bus_size;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  dma_minor_seq #(.AW(AW), .OW(OW), .NBW(NBW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
    .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size),
    .cfg_nbytes(cfg_nbytes), .busy(busy), .done(done), .cfg_err(cfg_err),
    .final_src_addr(final_src_addr), .final_dst_addr(final_dst_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] stream [64];
  logic exp_we [64];
  logic [AW-1:0] exp_addr [64];
  logic [1:0] exp_sz [64];
  int exp_n = 0, acc_idx = 0, seq_err = 0, hold_err = 0;
  int cyc = 0, last_wr_cyc = -10, done_cyc = -10, done_cnt = 0, err_cnt = 0, req_cnt = 0;
  int unsigned lat_seed = 1;
  int wait_left = 0;
  bit pend = 0;
  logic pend_we; logic [AW-1:0] pend_addr; logic [1:0] pend_sz; logic [31:0] pend_wd;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bus model and monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (done) begin done_cnt++; done_cyc = cyc; end
    if (cfg_err) err_cnt++;
    if (bus_req) req_cnt++;
    if (bus_req && pend) begin
      if (bus_we !== pend_we || bus_addr !== pend_addr || bus_size !== pend_sz ||
          bus_wdata !== pend_wd) hold_err++;
    end
    if (bus_req) begin
      if (wait_left == 0) begin
        bus_ack = 1'b1;
        pend = 0;
        if (acc_idx < exp_n) begin
          if (bus_we !== exp_we[acc_idx] || bus_addr !== exp_addr[acc_idx] ||
              bus_size !== exp_sz[acc_idx]) seq_err++;
        end else seq_err++;
        acc_idx++;
        if (bus_we) begin
          for (int k = 0; k < (1 << bus_size); k++)
            mem[8'(bus_addr + AW'(k))] = bus_wdata[k*8 +: 8];
          for (int k = (1 << bus_size); k < 4; k++)
            if (bus_wdata[k*8 +: 8] != 8'h00) seq_err++;
          last_wr_cyc = cyc;
        end else begin
          bus_rdata = '0;
          for (int k = 0; k < (1 << bus_size); k++)
            bus_rdata[k*8 +: 8] = mem[8'(bus_addr + AW'(k))];
        end
        lat_seed = lat_seed * 1103515245 + 12345;
        wait_left = int'((lat_seed >> 16) % 3);
      end else begin
        bus_ack = 1'b0;
        wait_left--;
        pend = 1; pend_we = bus_we; pend_addr = bus_addr; pend_sz = bus_size; pend_wd = bus_wdata;
      end
    end else begin
      bus_ack = 1'b0;
      pend = 0;
    end
  end

  task automatic clear_mon();
    acc_idx = 0; seq_err = 0; hold_err = 0; done_cnt = 0; err_cnt = 0; req_cnt = 0;
    done_cyc = -10; last_wr_cyc = -10;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input int ss, input int ds, input int nb, input int sstep,
                     input int dstep, input bit disturb);
    int sb, db, ub, nr, nw, r, w, n;
    logic [AW-1:0] sbase, dbase, fs, fd;
    bit mem_ok;
    sb = 1 << ss; db = 1 << ds; ub = (sb > db) ? sb : db;
    nr = nb / sb; nw = nb / db;
    sbase = 16'h0040; dbase = 16'h00C0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 29 + nb * 7 + ss * 3 + ds + 1);
      ref_mem[i] = mem[i];
    end
    for (int i = 0; i < nr; i++)
      for (int k = 0; k < sb; k++)
        stream[i*sb + k] = mem[8'(sbase + AW'(i * sstep) + AW'(k))];
    for (int i = 0; i < nw; i++)
      for (int k = 0; k < db; k++)
        ref_mem[8'(dbase + AW'(i * dstep) + AW'(k))] = stream[i*db + k];
    r = 0; w = 0; n = 0;
    for (int u = 0; u < nb / ub; u++) begin
      for (int i = 0; i < ub / sb; i++) begin
        exp_we[n] = 1'b0; exp_addr[n] = sbase + AW'(r * sstep); exp_sz[n] = 2'(ss); n++; r++;
      end
      for (int i = 0; i < ub / db; i++) begin
        exp_we[n] = 1'b1; exp_addr[n] = dbase + AW'(w * dstep); exp_sz[n] = 2'(ds); n++; w++;
      end
    end
    exp_n = n;
    fs = sbase + AW'(nr * sstep); fd = dbase + AW'(nw * dstep);
    clear_mon();
    cfg_src_addr = sbase; cfg_dst_addr = dbase;
    cfg_src_step = OW'(sstep); cfg_dst_step = OW'(dstep);
    cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds); cfg_nbytes = NBW'(nb);
    pulse_start();
    if (disturb) begin
      repeat (2) @(negedge clk);
      cfg_src_addr = 16'h0010; cfg_dst_addr = 16'h0090; cfg_src_step = 16'd1;
      cfg_dst_step = 16'd1; cfg_src_size = 2'd0; cfg_dst_size = 2'd0; cfg_nbytes = 8'd3;
      pulse_start();
    end
    for (int t = 0; t < 400 && done_cnt == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R6", "done pulse count", done_cnt, 1);
    chk(done_cyc == last_wr_cyc + 1, "R6", "done timing", done_cyc, last_wr_cyc + 1);
    chk(final_src_addr == fs, "R5", "final source address", final_src_addr, fs);
    chk(final_dst_addr == fd, "R5", "final destination address", final_dst_addr, fd);
    chk(acc_idx == nr + nw, "R1", "access count", acc_idx, nr + nw);
    chk(seq_err == 0, (ss == ds) ? "R2" : "R3", "access order mismatches", seq_err, 0);
    chk(hold_err == 0, "R8", "request changed while stalled", hold_err, 0);
    mem_ok = 1;
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) mem_ok = 0;
    chk(mem_ok, disturb ? "R9" : "R4", "destination contents match", mem_ok, 1);
    chk(err_cnt == 0, "R7", "no error on valid start", err_cnt, 0);
  endtask

  task automatic bad_cfg(input int ss, input int ds, input int nb);
    clear_mon(); exp_n = 0;
    cfg_src_addr = 16'h0040; cfg_dst_addr = 16'h00C0;
    cfg_src_step = 16'd1; cfg_dst_step = 16'd1;
    cfg_src_size = 2'(ss); cfg_dst_size = 2'(ds); cfg_nbytes = NBW'(nb);
    pulse_start();
    chk(cfg_err == 1'b1, "R7", "cfg_err the cycle after start", cfg_err, 1);
    repeat (6) @(negedge clk);
    chk(err_cnt == 1, "R7", "cfg_err pulse count", err_cnt, 1);
    chk(req_cnt == 0, "R7", "bus requests after rejected start", req_cnt, 0);
    chk(done_cnt == 0, "R7", "done after rejected start", done_cnt, 0);
  endtask

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    chk(0, "WATCHDOG", "run timed out", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req == 0 && busy == 0 && done == 0 && cfg_err == 0, "R10", "outputs in reset",
        {bus_req, busy, done, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_req == 0 && busy == 0, "R10", "idle after reset release", {bus_req, busy}, 0);
    for (int ss = 0; ss < 3; ss++)
      for (int ds = 0; ds < 3; ds++)
        for (int ni = 0; ni < 3; ni++)
          for (int si = 0; si < 3; si++)
            for (int di = 0; di < 3; di++) begin
              int sb, db, sst, dst;
              sb = 1 << ss; db = 1 << ds;
              sst = (si == 0) ? sb : (si == 1) ? -sb : 2 * sb;
              dst = (di == 0) ? db : (di == 1) ? -db : 0;
              run(ss, ds, 4 << ni, sst, dst, 1'b0);
            end
    run(0, 0, 3, 1, 1, 1'b0);
    run(1, 0, 6, 2, 1, 1'b0);
    run(0, 1, 10, -1, 2, 1'b0);
    run(1, 2, 16, 2, 4, 1'b1);
    run(2, 0, 16, -4, 1, 1'b1);
    bad_cfg(0, 0, 0);
    bad_cfg(2, 0, 6);
    bad_cfg(0, 1, 3);
    bad_cfg(3, 0, 4);
    bad_cfg(0, 3, 4);
    run(1, 1, 8, 2, 2, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule